// File: doc/BRIEF.md
# Virtual Address Access Checker

This block sits beside the load/store and fetch paths of a small processor and decides, for every memory access, whether it proceeds or faults. It takes a virtual address, the access kind, the current privilege, a configuration bit that says whether address translation exists, and the result of a lookup done by an external translation buffer: a hit flag, a physical page frame and three permission bits. The translation buffer's storage and replacement are not part of the block.

The pass/fault decision, the fault cause and the physical address are combinational in the request cycle. When an access faults, the block records fault information in three registers on the next clock edge. The first is the faulting address. The second is a page-table-entry address, made of a page-table base followed by the virtual page number. The third is a flag that tells a data access from an instruction fetch. A probe request gets the same pass/fault answer but leaves all three registers untouched. The page-table base field is loaded through its own load strobe.

Top module: `va_access_gate`

## Requirements
- R1: With `mmu_en` low, every request passes with `pa` equal to `va`, whatever the privilege, address or lookup result.
- R2: In supervisor mode with translation on, an address whose two top bits are both 1 (0xC0000000 and above) passes with `pa` equal to `va`, ignoring the lookup inputs.
- R3: In user mode with translation on, an address with bit 31 set faults with cause 1 (supervisor-only region). The page-table-entry address and the `tlb_d` flag keep their values.
- R4: Any other access that hits and holds the matching permission passes with `pa` = {`tlb_pfn`, `va[11:0]`}. The matching permission is read for a load (`acc`=00), write for a store (`acc`=01) and execute for a fetch (`acc`=1x). `pass` and `fault` are never high together, and both are low when `req` is low.
- R5: A hit without the matching permission faults with cause 3 for a load, 4 for a store and 5 for a fetch.
- R6: A lookup miss faults with cause 2. This also applies to supervisor addresses below 0xC0000000.
- R7: After a non-probe fault with cause 2 to 5, `tlb_d` reads 0 if the access was a fetch and 1 if it was a data access.
- R8: After a non-probe fault with cause 2 to 5, `pte_addr` keeps its base in bits [31:22], holds `va[31:12]` in bits [21:2], and has bits [1:0] at 0.
- R9: After any non-probe fault, `bad_addr` holds the full faulting virtual address.
- R10: A request with `probe` high reports `pass`/`fault`/`cause` as usual but changes none of `bad_addr`, `pte_addr` or `tlb_d`.
- R11: Reset clears `bad_addr`, `pte_addr` and `tlb_d`. A cycle with `ptb_load` high writes `ptb_val` into `pte_addr[31:22]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request valid this cycle |
| va | input | 32 | Virtual address |
| acc | input | 2 | Access kind: 00 load, 01 store, 1x fetch |
| sup | input | 1 | 1 = supervisor, 0 = user |
| mmu_en | input | 1 | Translation present |
| probe | input | 1 | Query only, no register side effects |
| tlb_hit | input | 1 | Lookup hit |
| tlb_pfn | input | 20 | Physical page frame from lookup |
| tlb_r | input | 1 | Read permitted |
| tlb_w | input | 1 | Write permitted |
| tlb_x | input | 1 | Execute permitted |
| ptb_load | input | 1 | Load page-table base field |
| ptb_val | input | 10 | New page-table base |
| pass | output | 1 | Access may proceed |
| fault | output | 1 | Access faults |
| cause | output | 3 | 0 none, 1 supervisor region, 2 miss, 3 read, 4 write, 5 execute |
| pa | output | 32 | Physical address (0 unless passing) |
| bad_addr | output | 32 | Last faulting virtual address |
| pte_addr | output | 32 | Page-table base and faulting page number |
| tlb_d | output | 1 | Last translation fault was a data access |

## Verification
The decision path is driven with addresses on both sides of the 0x80000000 and 0xC0000000 boundaries in both privileges. This separates the region bypass from the user region fault and from ordinary translated accesses. Each access kind is paired with a lookup result that grants every permission except the matching one, so a wrongly routed permission bit shows up as a wrong cause. A fault sequence with changing access kinds and page numbers then separates the fetch and data flag values and exposes any shift error in the page-number field. A probing miss follows, to show that the registers hold.

// File: rtl/va_access_gate.sv
module va_access_gate #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PTB_W     = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req,
  input  logic [VA_W-1:0]           va,
  input  logic [1:0]                acc,
  input  logic                      sup,
  input  logic                      mmu_en,
  input  logic                      probe,
  input  logic                      tlb_hit,
  input  logic [VA_W-PAGE_BITS-1:0] tlb_pfn,
  input  logic                      tlb_r,
  input  logic                      tlb_w,
  input  logic                      tlb_x,
  input  logic                      ptb_load,
  input  logic [PTB_W-1:0]          ptb_val,
  output logic                      pass,
  output logic                      fault,
  output logic [2:0]                cause,
  output logic [VA_W-1:0]           pa,
  output logic [VA_W-1:0]           bad_addr,
  output logic [PTB_W+VA_W-PAGE_BITS+1:0] pte_addr,
  output logic                      tlb_d
);
  localparam int VPN_W = VA_W - PAGE_BITS;

  localparam logic [2:0] C_NONE  = 3'd0;
  localparam logic [2:0] C_SUPER = 3'd1;
  localparam logic [2:0] C_MISS  = 3'd2;
  localparam logic [2:0] C_RD    = 3'd3;
  localparam logic [2:0] C_WR    = 3'd4;
  localparam logic [2:0] C_EX    = 3'd5;

  logic             is_fetch, is_store, perm_ok, kern_bypass, user_high;
  logic [2:0]       cause_c;
  logic [VA_W-1:0]  pa_c;
  logic             commit, tlb_fault;
  logic [PTB_W-1:0] ptb_q;
  logic [VPN_W-1:0] vpn_q;

  assign is_fetch    = acc[1];
  assign is_store    = (acc == 2'b01);
  assign perm_ok     = is_fetch ? tlb_x : (is_store ? tlb_w : tlb_r);
  assign kern_bypass = sup && (&va[VA_W-1:VA_W-2]);
  assign user_high   = !sup && va[VA_W-1];

  always_comb begin
    cause_c = C_NONE;
    pa_c    = '0;
    if (!mmu_en || kern_bypass) begin
      pa_c = va;
    end else if (user_high) begin
      cause_c = C_SUPER;
    end else if (!tlb_hit) begin
      cause_c = C_MISS;
    end else if (!perm_ok) begin
      cause_c = is_fetch ? C_EX : (is_store ? C_WR : C_RD);
    end else begin
      pa_c = {tlb_pfn, va[PAGE_BITS-1:0]};
    end
  end

  assign pass      = req && (cause_c == C_NONE);
  assign fault     = req && (cause_c != C_NONE);
  assign cause     = req ? cause_c : C_NONE;
  assign pa        = pass ? pa_c : '0;
  assign commit    = fault && !probe;
  assign tlb_fault = commit && (cause_c != C_SUPER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bad_addr <= '0;
      ptb_q    <= '0;
      vpn_q    <= '0;
      tlb_d    <= 1'b0;
    end else begin
      if (commit) bad_addr <= va;
      if (tlb_fault) begin
        tlb_d <= !is_fetch;
        vpn_q <= va[VA_W-1:PAGE_BITS];
      end
      if (ptb_load) ptb_q <= ptb_val;
    end
  end

  assign pte_addr = {ptb_q, vpn_q, 2'b00};
endmodule

// File: rtl/va_access_gate_chk.sv
module va_access_gate_chk #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PTB_W     = 10
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req,
  input logic [VA_W-1:0]           va,
  input logic [1:0]                acc,
  input logic                      sup,
  input logic                      mmu_en,
  input logic                      probe,
  input logic                      ptb_load,
  input logic                      pass,
  input logic                      fault,
  input logic [2:0]                cause,
  input logic [VA_W-1:0]           pa,
  input logic [VA_W-1:0]           bad_addr,
  input logic [PTB_W+VA_W-PAGE_BITS+1:0] pte_addr,
  input logic                      tlb_d
);
  // R1
  nommu_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && !mmu_en |-> pass && (pa == va));

  // R3
  user_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && mmu_en && !sup && va[VA_W-1] |-> fault && (cause == 3'd1));

  // R4
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fault) && (req || (!pass && !fault)));

  // R7
  dflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !probe && (cause != 3'd1) |=> tlb_d == !$past(acc[1]));

  // R9
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !probe |=> bad_addr == $past(va));

  // R10
  probe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && probe && !ptb_load |=> $stable(bad_addr) && $stable(pte_addr) && $stable(tlb_d));
endmodule

bind va_access_gate va_access_gate_chk #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PTB_W(PTB_W)) u_chk (.*);

// File: tb/tb_va_access_gate.sv
module tb_va_access_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] va = '0;
  logic [1:0]  acc = '0;
  logic        sup = 1'b0, mmu_en = 1'b0, probe = 1'b0;
  logic        tlb_hit = 1'b0, tlb_r = 1'b0, tlb_w = 1'b0, tlb_x = 1'b0;
  logic [19:0] tlb_pfn = '0;
  logic        ptb_load = 1'b0;
  logic [9:0]  ptb_val = '0;
  logic        pass, fault, tlb_d;
  logic [2:0]  cause;
  logic [31:0] pa, bad_addr, pte_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  va_access_gate dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [1:0] k, input logic s,
                       input logic m, input logic h, input logic [19:0] f,
                       input logic [2:0] rwx, input logic pr);
    @(negedge clk);
    req = 1'b1; va = a; acc = k; sup = s; mmu_en = m; tlb_hit = h; tlb_pfn = f;
    {tlb_r, tlb_w, tlb_x} = rwx; probe = pr;
    #1;
  endtask

  task automatic finish_req;
    @(posedge clk);
    #1;
    req = 1'b0; probe = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 bad_addr reset", bad_addr, 32'h0);
    chk("R11 pte_addr reset", pte_addr, 32'h0);
    chk("R11 tlb_d reset", {31'b0, tlb_d}, 32'h0);
    chk("R4 idle no pass/fault", {30'b0, pass, fault}, 32'h0);
  endtask

  task automatic t_nommu;
    drive(32'hF000_1234, 2'b10, 1'b0, 1'b0, 1'b0, 20'h0, 3'b000, 1'b0);
    chk("R1 pass", {31'b0, pass}, 32'h1);
    chk("R1 pa", pa, 32'hF000_1234);
    finish_req();
    chk("R1 no record", bad_addr, 32'h0);
  endtask

  task automatic t_kernel;
    drive(32'hC000_1234, 2'b01, 1'b1, 1'b1, 1'b1, 20'hAAAAA, 3'b000, 1'b0);
    chk("R2 pass", {31'b0, pass}, 32'h1);
    chk("R2 pa", pa, 32'hC000_1234);
    finish_req();
  endtask

  task automatic t_ptb;
    @(negedge clk);
    ptb_load = 1'b1; ptb_val = 10'h2A5;
    @(negedge clk);
    ptb_load = 1'b0;
    chk("R11 ptb load", pte_addr, 32'hA940_0000);
  endtask

  task automatic t_user_high;
    drive(32'h8000_0010, 2'b00, 1'b0, 1'b1, 1'b1, 20'h1, 3'b111, 1'b0);
    chk("R3 cause", {29'b0, cause}, 32'd1);
    finish_req();
    chk("R3 R9 bad_addr", bad_addr, 32'h8000_0010);
    chk("R3 pte kept", pte_addr, 32'hA940_0000);
    chk("R3 d kept", {31'b0, tlb_d}, 32'h0);
  endtask

  task automatic t_hits;
    drive(32'h1234_5678, 2'b00, 1'b1, 1'b1, 1'b1, 20'h00ABC, 3'b100, 1'b0);
    chk("R4 load hit pa", pa, 32'h00AB_C678);
    finish_req();
    drive(32'h0000_1FFC, 2'b10, 1'b0, 1'b1, 1'b1, 20'h12345, 3'b001, 1'b0);
    chk("R4 fetch hit pa", pa, 32'h1234_5FFC);
    finish_req();
    drive(32'h7FFF_F008, 2'b01, 1'b0, 1'b1, 1'b1, 20'h00001, 3'b010, 1'b0);
    chk("R4 store hit pa", pa, 32'h0000_1008);
    finish_req();
    chk("R4 no record", bad_addr, 32'h8000_0010);
  endtask

  task automatic t_perm;
    drive(32'h0040_3004, 2'b01, 1'b1, 1'b1, 1'b1, 20'h5, 3'b101, 1'b0);
    chk("R5 write cause", {29'b0, cause}, 32'd4);
    finish_req();
    chk("R9 bad", bad_addr, 32'h0040_3004);
    chk("R7 d data", {31'b0, tlb_d}, 32'h1);
    chk("R8 pte", pte_addr, 32'hA940_100C);
    drive(32'h7FFF_F000, 2'b10, 1'b0, 1'b1, 1'b1, 20'h5, 3'b110, 1'b0);
    chk("R5 exec cause", {29'b0, cause}, 32'd5);
    finish_req();
    chk("R7 d fetch", {31'b0, tlb_d}, 32'h0);
    chk("R8 pte", pte_addr, 32'hA95F_FFFC);
    drive(32'h0000_0000, 2'b00, 1'b0, 1'b1, 1'b1, 20'h5, 3'b011, 1'b0);
    chk("R5 read cause", {29'b0, cause}, 32'd3);
    finish_req();
    chk("R7 d load", {31'b0, tlb_d}, 32'h1);
    chk("R8 pte", pte_addr, 32'hA940_0000);
  endtask

  task automatic t_miss;
    drive(32'hBFFF_FFFF, 2'b11, 1'b1, 1'b1, 1'b0, 20'h0, 3'b111, 1'b0);
    chk("R6 miss cause", {29'b0, cause}, 32'd2);
    finish_req();
    chk("R9 bad", bad_addr, 32'hBFFF_FFFF);
    chk("R7 d fetch", {31'b0, tlb_d}, 32'h0);
    chk("R8 pte", pte_addr, 32'hA96F_FFFC);
  endtask

  task automatic t_probe;
    drive(32'h1111_1000, 2'b01, 1'b0, 1'b1, 1'b0, 20'h0, 3'b111, 1'b1);
    chk("R10 probe fault", {31'b0, fault}, 32'h1);
    chk("R10 probe cause", {29'b0, cause}, 32'd2);
    finish_req();
    chk("R10 bad kept", bad_addr, 32'hBFFF_FFFF);
    chk("R10 pte kept", pte_addr, 32'hA96F_FFFC);
    chk("R10 d kept", {31'b0, tlb_d}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_nommu();
    t_kernel();
    t_ptb();
    t_user_high();
    t_hits();
    t_perm();
    t_miss();
    t_probe();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule